// File: doc/BRIEF.md
# Debug Mode Entry Controller

This block sits beside a core's trap logic and decides what happens to each trap the core reports. A breakpoint taken at a privilege level whose breakpoint-enable bit is set moves the core into debug mode. A trap taken while the core is already in debug mode is steered to one of two fixed debug ROM addresses. Any other trap is handed on, untouched, to the normal trap logic. The block owns the debug control/status word, the saved debug pc and a debug scratch word, and exposes all three through a small CSR read/write port.

Each trap is a single-cycle `trap_valid` pulse with its cause, pc and current privilege. One cycle later the block raises exactly one of `enter_dbg`, `redirect_dbg` or `pass_trap`, with a pc override and a privilege override where they apply. The block also maps privilege change requests so that the hypervisor level, which is not implemented, becomes user level. There is no data stream here, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: A trap whose cause equals `BRK_CODE` (default 3), taken outside debug mode at privilege p (U=0, S=1, H=2, M=3), enters debug mode when enable bit p is set (bits 12+p of the status word). The status word's cause field, bits [8:6], then reads 1, which means software breakpoint.
- R2: On debug entry, in the cycle after the trap, the block drives `pc_ovr` = `ROM_ENTRY` and `priv_ovr` = 3 (machine), each with its valid flag set. It also stores the trapping privilege into status bits [1:0] and the trap pc into the debug pc.
- R3: While the cause field is nonzero (`in_debug`=1), a breakpoint trap gives `redirect_dbg` with `pc_ovr` = `ROM_ENTRY`, and any other cause gives `ROM_EXC`. The debug pc, the saved privilege and the cause do not change, and no privilege override is given.
- R4: A trap outside debug mode that does not meet R1 raises `pass_trap`. No pc or privilege override is given, and the debug state does not change.
- R5: Power-on reset (`rst_n` low) loads the halt bit (status bit 3) from `halt_strap` and clears everything else. A later core reset (`core_rst`) clears all state including the halt bit, whatever the strap, so the strap acts only once.
- R6: The status word (CSR address 0) always reads bits [31:30]=01 (debug version 1). Bits 29, 28, 10 and 9 read 0, as do all bits not named in R1, R2, R5 and R7.
- R7: A write to the status word changes only bits [1:0], bit 2 (step, shown on `dbg_step`), bits [15:12] (the enables) and bit 3 (halt, shown on `dbg_halt`). Writing ones to the cause field or to the constant fields has no effect.
- R8: A privilege request (`priv_req_valid`) with no trap in the same cycle gives `priv_ovr_valid` in the next cycle. A request for 2 (H) comes out as 0 (U), and any other value comes out unchanged.
- R9: Each `trap_valid` pulse produces exactly one of `enter_dbg`, `redirect_dbg` and `pass_trap`, one cycle later. None of them is raised without a trap.
- R10: CSR address 1 holds the debug pc and address 2 the debug scratch word. Both can be written in full, and `csr_rdata` shows the addressed word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| core_rst | input | 1 | Synchronous core reset that clears debug state |
| halt_strap | input | 1 | Halt-at-power-on strap |
| trap_valid | input | 1 | One-cycle trap report |
| trap_cause | input | CAUSE_W | Exception cause code |
| trap_pc | input | XLEN | pc of the trapping instruction |
| cur_priv | input | 2 | Current privilege (U=0, S=1, H=2, M=3) |
| priv_req_valid | input | 1 | Privilege change request |
| priv_req | input | 2 | Requested privilege |
| csr_addr | input | 2 | 0 status, 1 debug pc, 2 scratch |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data |
| pc_ovr_valid | output | 1 | pc override present |
| pc_ovr | output | XLEN | Next-pc override |
| enter_dbg | output | 1 | Trap entered debug mode |
| redirect_dbg | output | 1 | Trap redirected within debug mode |
| pass_trap | output | 1 | Trap handed to normal trap logic |
| priv_ovr_valid | output | 1 | Privilege override present |
| priv_ovr | output | 2 | Privilege override value |
| in_debug | output | 1 | Cause field is nonzero |
| dbg_step | output | 1 | Step bit |
| dbg_halt | output | 1 | Halt bit |
| dpc_out | output | XLEN | Debug pc |

## Verification
The assertions assume that `trap_valid` lasts one cycle and that each trap is separated from the next by at least one idle cycle. They also assume that a privilege request never arrives in the same cycle as a trap, and that the status word is not written in the cycle of a trap. The stimulus keeps to this by driving every trap, CSR write and privilege request from its own task, one operation at a time, with an idle cycle after each. Under these conditions the one-outcome rule, the entry overrides and the stability of the debug state inside debug mode can be stated cycle by cycle against the trap inputs.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  typedef enum logic [2:0] {
    OC_NONE,
    OC_PASS,
    OC_ENTER,
    OC_REDIR_BRK,
    OC_REDIR_EXC
  } outcome_e;

  localparam logic [2:0] CAUSE_SWBP = 3'd1;
  localparam int         NUM_PRIV   = 4;

  // status word layout, decoded by the debugger
  localparam int POS_PRV  = 0;
  localparam int POS_STEP = 2;
  localparam int POS_HALT = 3;
  localparam int POS_CAU  = 6;
  localparam int POS_EBRK = 12;
  localparam int POS_VER  = 30;

  localparam logic [1:0] CSR_STATUS  = 2'd0;
  localparam logic [1:0] CSR_DPC     = 2'd1;
  localparam logic [1:0] CSR_SCRATCH = 2'd2;

  typedef struct packed {
    logic [2:0]          cause;
    logic [1:0]          prv;
    logic                step;
    logic [NUM_PRIV-1:0] ebreak;
    logic                halt;
  } dstat_t;
endpackage

// File: rtl/dbg_classify.sv
module dbg_classify
  import dbg_pkg::*;
#(
  parameter int          CAUSE_W  = 5,
  parameter int unsigned BRK_CODE = 3
) (
  input  logic                trap_valid,
  input  logic [CAUSE_W-1:0]  trap_cause,
  input  logic [1:0]          cur_priv,
  input  logic                in_debug,
  input  logic [NUM_PRIV-1:0] ebreak,
  output outcome_e            outcome
);
  logic [NUM_PRIV-1:0] hit;
  logic                is_brk;

  assign is_brk = (trap_cause == CAUSE_W'(BRK_CODE));

  for (genvar g = 0; g < NUM_PRIV; g++) begin : g_hit
    assign hit[g] = ebreak[g] && (cur_priv == 2'(g));
  end

  always_comb begin
    outcome = OC_NONE;
    if (trap_valid) begin
      if (in_debug)
        outcome = is_brk ? OC_REDIR_BRK : OC_REDIR_EXC;
      else if (is_brk && (|hit))
        outcome = OC_ENTER;
      else
        outcome = OC_PASS;
    end
  end
endmodule

// File: rtl/dbg_priv_map.sv
module dbg_priv_map
  import dbg_pkg::*;
(
  input  logic [1:0] req,
  output logic [1:0] granted
);
  assign granted = (req == PRIV_H) ? PRIV_U : req;
endmodule

// File: rtl/dbg_state.sv
module dbg_state
  import dbg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            core_rst,
  input  logic            halt_strap,
  input  logic            enter,
  input  logic [XLEN-1:0] trap_pc,
  input  logic [1:0]      cur_priv,
  input  logic [1:0]      csr_addr,
  input  logic            csr_we,
  input  logic [XLEN-1:0] csr_wdata,
  output dstat_t          stat,
  output logic [XLEN-1:0] dpc,
  output logic [XLEN-1:0] csr_rdata
);
  logic [XLEN-1:0] scratch;
  logic [31:0]     stat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat      <= '0;
      stat.halt <= halt_strap;
      dpc       <= '0;
      scratch   <= '0;
    end else if (core_rst) begin
      stat    <= '0;
      dpc     <= '0;
      scratch <= '0;
    end else begin
      if (csr_we) begin
        case (csr_addr)
          CSR_STATUS: begin
            stat.prv    <= csr_wdata[POS_PRV +: 2];
            stat.step   <= csr_wdata[POS_STEP];
            stat.halt   <= csr_wdata[POS_HALT];
            stat.ebreak <= csr_wdata[POS_EBRK +: NUM_PRIV];
          end
          CSR_DPC:     dpc     <= csr_wdata;
          CSR_SCRATCH: scratch <= csr_wdata;
          default: ;
        endcase
      end
      if (enter) begin
        stat.cause <= CAUSE_SWBP;
        stat.prv   <= cur_priv;
        dpc        <= trap_pc;
      end
    end
  end

  always_comb begin
    stat_word = '0;
    stat_word[POS_VER +: 2]        = 2'b01;
    stat_word[POS_EBRK +: NUM_PRIV] = stat.ebreak;
    stat_word[POS_CAU +: 3]        = stat.cause;
    stat_word[POS_HALT]            = stat.halt;
    stat_word[POS_STEP]            = stat.step;
    stat_word[POS_PRV +: 2]        = stat.prv;
  end

  always_comb begin
    case (csr_addr)
      CSR_STATUS:  csr_rdata = XLEN'(stat_word);
      CSR_DPC:     csr_rdata = dpc;
      CSR_SCRATCH: csr_rdata = scratch;
      default:     csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              CAUSE_W   = 5,
  parameter int unsigned     BRK_CODE  = 3,
  parameter logic [XLEN-1:0] ROM_ENTRY = XLEN'(32'h0000_0800),
  parameter logic [XLEN-1:0] ROM_EXC   = XLEN'(32'h0000_0808)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_rst,
  input  logic               halt_strap,
  input  logic               trap_valid,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [1:0]         cur_priv,
  input  logic               priv_req_valid,
  input  logic [1:0]         priv_req,
  input  logic [1:0]         csr_addr,
  input  logic               csr_we,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               pc_ovr_valid,
  output logic [XLEN-1:0]    pc_ovr,
  output logic               enter_dbg,
  output logic               redirect_dbg,
  output logic               pass_trap,
  output logic               priv_ovr_valid,
  output logic [1:0]         priv_ovr,
  output logic               in_debug,
  output logic               dbg_step,
  output logic               dbg_halt,
  output logic [XLEN-1:0]    dpc_out
);
  outcome_e   outcome;
  dstat_t     stat;
  logic [1:0] req_mapped;

  assign in_debug = (stat.cause != 3'd0);
  assign dbg_step = stat.step;
  assign dbg_halt = stat.halt;

  dbg_classify #(.CAUSE_W(CAUSE_W), .BRK_CODE(BRK_CODE)) i_classify (
    .trap_valid (trap_valid),
    .trap_cause (trap_cause),
    .cur_priv   (cur_priv),
    .in_debug   (in_debug),
    .ebreak     (stat.ebreak),
    .outcome    (outcome)
  );

  dbg_state #(.XLEN(XLEN)) i_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_rst   (core_rst),
    .halt_strap (halt_strap),
    .enter      (outcome == OC_ENTER),
    .trap_pc    (trap_pc),
    .cur_priv   (cur_priv),
    .csr_addr   (csr_addr),
    .csr_we     (csr_we),
    .csr_wdata  (csr_wdata),
    .stat       (stat),
    .dpc        (dpc_out),
    .csr_rdata  (csr_rdata)
  );

  dbg_priv_map i_priv_map (
    .req     (priv_req),
    .granted (req_mapped)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enter_dbg      <= 1'b0;
      redirect_dbg   <= 1'b0;
      pass_trap      <= 1'b0;
      pc_ovr_valid   <= 1'b0;
      pc_ovr         <= '0;
      priv_ovr_valid <= 1'b0;
      priv_ovr       <= PRIV_U;
    end else begin
      enter_dbg      <= 1'b0;
      redirect_dbg   <= 1'b0;
      pass_trap      <= 1'b0;
      pc_ovr_valid   <= 1'b0;
      priv_ovr_valid <= 1'b0;
      if (!core_rst) begin
        case (outcome)
          OC_ENTER: begin
            enter_dbg      <= 1'b1;
            pc_ovr_valid   <= 1'b1;
            pc_ovr         <= ROM_ENTRY;
            priv_ovr_valid <= 1'b1;
            priv_ovr       <= PRIV_M;
          end
          OC_REDIR_BRK: begin
            redirect_dbg <= 1'b1;
            pc_ovr_valid <= 1'b1;
            pc_ovr       <= ROM_ENTRY;
          end
          OC_REDIR_EXC: begin
            redirect_dbg <= 1'b1;
            pc_ovr_valid <= 1'b1;
            pc_ovr       <= ROM_EXC;
          end
          OC_PASS: pass_trap <= 1'b1;
          default: begin
            if (priv_req_valid) begin
              priv_ovr_valid <= 1'b1;
              priv_ovr       <= req_mapped;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg_entry_ctrl_chk.sv
module dbg_entry_ctrl_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            core_rst,
  input logic            trap_valid,
  input logic [XLEN-1:0] trap_pc,
  input logic            enter_dbg,
  input logic            redirect_dbg,
  input logic            pass_trap,
  input logic            pc_ovr_valid,
  input logic            priv_ovr_valid,
  input logic [1:0]      priv_ovr,
  input logic            in_debug,
  input logic [XLEN-1:0] dpc_out
);
  // R9: one outcome per trap, none without a trap
  a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n || core_rst)
    trap_valid |=> ($countones({enter_dbg, redirect_dbg, pass_trap}) == 1));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n || core_rst)
    !trap_valid |=> ({enter_dbg, redirect_dbg, pass_trap} == 3'b000));
  // R2: entry overrides privilege to machine and saves the pc
  a_r2_enter_ovr: assert property (@(posedge clk) disable iff (!rst_n || core_rst)
    enter_dbg |-> (priv_ovr_valid && priv_ovr == 2'd3 && pc_ovr_valid && in_debug));
  a_r2_dpc_saved: assert property (@(posedge clk) disable iff (!rst_n || core_rst)
    enter_dbg |-> (dpc_out == $past(trap_pc)));
  // R3: redirect inside debug leaves the debug pc and privilege alone
  a_r3_redir_quiet: assert property (@(posedge clk) disable iff (!rst_n || core_rst)
    redirect_dbg |-> ($stable(dpc_out) && !priv_ovr_valid && pc_ovr_valid));
  // R3: debug mode persists until a reset
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n || core_rst)
    in_debug |=> in_debug);
  // R4: pass-through carries no override
  a_r4_pass_clean: assert property (@(posedge clk) disable iff (!rst_n || core_rst)
    pass_trap |-> (!pc_ovr_valid && !priv_ovr_valid));
  // R8: hypervisor level never granted
  a_r8_no_h: assert property (@(posedge clk) disable iff (!rst_n || core_rst)
    priv_ovr_valid |-> (priv_ovr != 2'd2));
endmodule

bind dbg_entry_ctrl dbg_entry_ctrl_chk #(.XLEN(XLEN)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .core_rst       (core_rst),
  .trap_valid     (trap_valid),
  .trap_pc        (trap_pc),
  .enter_dbg      (enter_dbg),
  .redirect_dbg   (redirect_dbg),
  .pass_trap      (pass_trap),
  .pc_ovr_valid   (pc_ovr_valid),
  .priv_ovr_valid (priv_ovr_valid),
  .priv_ovr       (priv_ovr),
  .in_debug       (in_debug),
  .dpc_out        (dpc_out)
);

// File: tb/test_dbg_entry_ctrl.sv
module test_dbg_entry_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        e, r, p, pcv, qv;
    logic [31:0] pc;
    logic [1:0]  q;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_rst = 1'b0;
  logic        halt_strap = 1'b1;
  logic        trap_valid = 1'b0;
  logic [4:0]  trap_cause = '0;
  logic [31:0] trap_pc = '0;
  logic [1:0]  cur_priv = '0;
  logic        priv_req_valid = 1'b0;
  logic [1:0]  priv_req = '0;
  logic [1:0]  csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata, pc_ovr, dpc_out;
  logic        pc_ovr_valid, enter_dbg, redirect_dbg, pass_trap;
  logic        priv_ovr_valid, in_debug, dbg_step, dbg_halt;
  logic [1:0]  priv_ovr;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_entry_ctrl i_dbg_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst), .halt_strap(halt_strap),
    .trap_valid(trap_valid), .trap_cause(trap_cause), .trap_pc(trap_pc),
    .cur_priv(cur_priv), .priv_req_valid(priv_req_valid), .priv_req(priv_req),
    .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .pc_ovr_valid(pc_ovr_valid), .pc_ovr(pc_ovr),
    .enter_dbg(enter_dbg), .redirect_dbg(redirect_dbg), .pass_trap(pass_trap),
    .priv_ovr_valid(priv_ovr_valid), .priv_ovr(priv_ovr), .in_debug(in_debug),
    .dbg_step(dbg_step), .dbg_halt(dbg_halt), .dpc_out(dpc_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected result per reported outcome
  always @(negedge clk) begin
    if (rst_n && !core_rst && (enter_dbg || redirect_dbg || pass_trap || priv_ovr_valid)) begin
      if (sb.size() == 0) begin
        check("R9 unexpected outcome", {27'd0, enter_dbg, redirect_dbg, pass_trap, pc_ovr_valid, priv_ovr_valid}, 32'd0);
      end else begin
        exp_t x;
        x = sb.pop_front();
        check({x.tag, " flags"},
              {27'd0, enter_dbg, redirect_dbg, pass_trap, pc_ovr_valid, priv_ovr_valid},
              {27'd0, x.e, x.r, x.p, x.pcv, x.qv});
        if (x.pcv) check({x.tag, " pc_ovr"}, pc_ovr, x.pc);
        if (x.qv)  check({x.tag, " priv_ovr"}, {30'd0, priv_ovr}, {30'd0, x.q});
      end
    end
  end

  task automatic push(input string tag, input logic e, input logic r, input logic p,
                      input logic pcv, input logic [31:0] pc, input logic qv, input logic [1:0] q);
    exp_t x;
    x.tag = tag; x.e = e; x.r = r; x.p = p; x.pcv = pcv; x.pc = pc; x.qv = qv; x.q = q;
    sb.push_back(x);
  endtask

  task automatic do_trap(input logic [4:0] cause, input logic [31:0] pc, input logic [1:0] prv);
    @(negedge clk);
    trap_valid = 1'b1; trap_cause = cause; trap_pc = pc; cur_priv = prv;
    @(negedge clk);
    trap_valid = 1'b0;
  endtask

  task automatic do_priv(input logic [1:0] req);
    @(negedge clk);
    priv_req_valid = 1'b1; priv_req = req;
    @(negedge clk);
    priv_req_valid = 1'b0;
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_chk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    @(negedge clk);
    csr_addr = a;
    #1;
    check(tag, csr_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5, R6: power-on state with strap set
    csr_chk("R5 R6 status after power-on", 2'd0, 32'h4000_0008);
    check("R5 halt bit", {31'd0, dbg_halt}, 32'd1);
    check("R5 not in debug", {31'd0, in_debug}, 32'd0);
    csr_chk("R5 dpc reset", 2'd1, 32'h0);

    // R7: only writable fields change; cause and constants ignored
    csr_wr(2'd0, 32'h3000_91C5 | 32'h0000_0600);
    csr_chk("R7 status write", 2'd0, 32'h4000_9005);
    check("R7 step out", {31'd0, dbg_step}, 32'd1);
    check("R7 halt cleared", {31'd0, dbg_halt}, 32'd0);
    check("R7 cause not written", {31'd0, in_debug}, 32'd0);

    // R4: breakpoint at S with S enable clear, and a non-breakpoint at M
    push("R4 brk S disabled", 0, 0, 1, 0, 32'h0, 0, 2'd0);
    do_trap(5'd3, 32'h0000_1000, 2'd1);
    push("R4 other cause at M", 0, 0, 1, 0, 32'h0, 0, 2'd0);
    do_trap(5'd2, 32'h0000_1004, 2'd3);
    csr_chk("R4 dpc unchanged", 2'd1, 32'h0);
    csr_chk("R4 status unchanged", 2'd0, 32'h4000_9005);

    // R8: privilege mapping
    push("R8 H maps to U", 0, 0, 0, 0, 32'h0, 1, 2'd0);
    do_priv(2'd2);
    push("R8 S passes", 0, 0, 0, 0, 32'h0, 1, 2'd1);
    do_priv(2'd1);
    push("R8 M passes", 0, 0, 0, 0, 32'h0, 1, 2'd3);
    do_priv(2'd3);

    // R1, R2: breakpoint at U enters debug
    push("R1 R2 enter from U", 1, 0, 0, 1, 32'h0000_0800, 1, 2'd3);
    do_trap(5'd3, 32'h0000_1234, 2'd0);
    check("R1 in_debug", {31'd0, in_debug}, 32'd1);
    csr_chk("R2 dpc saved", 2'd1, 32'h0000_1234);
    csr_chk("R1 R2 status after entry", 2'd0, 32'h4000_9044);

    // R3: inside debug
    push("R3 other cause to exc rom", 0, 1, 0, 1, 32'h0000_0808, 0, 2'd0);
    do_trap(5'd5, 32'h0000_0900, 2'd3);
    push("R3 brk to entry rom", 0, 1, 0, 1, 32'h0000_0800, 0, 2'd0);
    do_trap(5'd3, 32'h0000_0904, 2'd3);
    csr_chk("R3 dpc kept", 2'd1, 32'h0000_1234);
    csr_chk("R3 status kept", 2'd0, 32'h4000_9044);

    // R10: scratch and dpc access
    csr_wr(2'd2, 32'hDEAD_BEEF);
    csr_chk("R10 scratch", 2'd2, 32'hDEAD_BEEF);
    csr_wr(2'd1, 32'h0000_4440);
    csr_chk("R10 dpc write", 2'd1, 32'h0000_4440);
    csr_chk("R10 status read", 2'd0, 32'h4000_9044);

    // R5: core reset clears halt even with strap high
    csr_wr(2'd0, 32'h0000_4008);
    @(negedge clk); core_rst = 1'b1;
    @(negedge clk); core_rst = 1'b0;
    csr_chk("R5 status after core reset", 2'd0, 32'h4000_0000);
    check("R5 halt cleared on core reset", {31'd0, dbg_halt}, 32'd0);
    check("R5 left debug", {31'd0, in_debug}, 32'd0);
    csr_chk("R5 scratch cleared", 2'd2, 32'h0);

    // R4 after reset: M enable now clear
    push("R4 brk M after reset", 0, 0, 1, 0, 32'h0, 0, 2'd0);
    do_trap(5'd3, 32'h0000_2000, 2'd3);

    // R1: entry at H uses the H enable (bit 14)
    csr_wr(2'd0, 32'h0000_4000);
    push("R1 enter from H", 1, 0, 0, 1, 32'h0000_0800, 1, 2'd3);
    do_trap(5'd3, 32'h0000_3000, 2'd2);
    csr_chk("R1 R2 status H entry", 2'd0, 32'h4000_4042);
    csr_chk("R2 dpc H entry", 2'd1, 32'h0000_3000);

    repeat (2) @(negedge clk);
    check("R9 all outcomes seen", sb.size(), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule